// File: doc/BRIEF.md
# Handshaked Mailbox Byte Sequencer

This block is the controller-side engine of a byte-serial mailbox that links a host to a power-management controller. The host signals each byte transfer with two active-low lines held in an 8-bit port register. The block answers every valid request by pulling its acknowledge line low, and it moves one byte through a shift-register style interface. It then raises a one-cycle shift-done pulse. The first byte of a transaction is an opcode. A built-in per-opcode length table decides how many argument bytes follow, whether an explicit count byte comes first, and how long the reply is.

Once the arguments are in, the block raises a one-cycle dispatch strobe for recognised opcodes. An external executor reads the stored arguments, fills a reply buffer and signals that the reply is ready. The block then streams the reply bytes back to the host under the same handshake. For unrecognised opcodes the block builds an all-zero reply by itself, with no dispatch. A hold output stays high for the whole transaction so that a background bus poller can be paused.

Top module: `mbox_byte_seq`

## Requirements
- R1: After reset the port register reads 0x18 (bit 4 = host request, bit 3 = acknowledge, both high = idle, other bits 0), poll_hold is low and no pulse output is high.
- R2: When the port value differs from the last value the block saw, and shows bit 4 low with bit 3 high, the block clears bit 3 at the next edge and handles exactly one byte, pulsing sr_done in the same cycle as the clear.
- R3: When a changed port value shows bit 4 high with bit 3 low (acknowledge release), the block sets bit 3 high again and handles no byte.
- R4: A changed port value with bits 4 and 3 both low gives a one-cycle hs_err pulse; no byte is handled and the port is left as it is. Writing a value equal to the last one seen causes no action.
- R5: In idle and while receiving, sr_dir_out must be 1 (host to block); while replying it must be 0. On a mismatch the request is still acknowledged, but proto_err pulses instead of sr_done and the byte is not consumed.
- R6: The length table, written as (argument bytes, reply bytes, with V meaning variable):
  - 0x10 = (1, 0)
  - 0x20 = (V, 0)
  - 0x30 = (4, 0)
  - 0x38 = (0, 4)
  - 0x78 = (0, V)
  - 0xE8 = (0, 1)
  - any other opcode is unknown, with 0 argument bytes and a reply of V when bit 0 is set, otherwise bits 2:1 bytes.
  Received arguments can be read back through arg_ridx/arg_rdata, with their count on arg_cnt.
- R7: For a variable argument length, the byte after the opcode is the argument count; a count of 0 completes the command at once.
- R8: Arguments beyond 32 are dropped. arg_cnt saturates at 32, and the command still completes only after the full announced count.
- R9: A recognised opcode whose arguments are complete gives one disp_stb pulse with disp_op set. Requests that arrive before rsp_ready are neither acknowledged nor lost; they are served once the reply is ready.
- R10: A fixed reply length N sends exactly N bytes from the reply buffer. Bytes at positions at or past rsp_cnt are sent as 0x00.
- R11: A variable reply sends rsp_cnt first, then that many buffer bytes.
- R12: An unknown opcode is never dispatched. Its reply is N zero bytes for a fixed length N, or a single 0x00 count byte for a variable length. With N = 0 the block returns to idle straight after the opcode.
- R13: poll_hold rises with the accepted opcode and falls when the last reply byte has been sent, or when the command needs no reply bytes and is finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wr | input | 1 | Host write strobe for the port register (a host write wins over the block in the same cycle) |
| port_wdata | input | 8 | Value written by the host |
| port_q | output | 8 | Port register, including the handshake bits |
| sr_dir_out | input | 1 | Shift direction: 1 = host to block, 0 = block to host |
| sr_in | input | 8 | Byte from the host |
| sr_out | output | 8 | Byte to the host, valid from the sr_done pulse |
| sr_done | output | 1 | Shift-done pulse, one per handled byte |
| proto_err | output | 1 | Direction-mismatch pulse |
| hs_err | output | 1 | Invalid handshake state pulse |
| poll_hold | output | 1 | Pause request for the background poller |
| disp_stb | output | 1 | Dispatch strobe |
| disp_op | output | 8 | Opcode of the current transaction |
| arg_cnt | output | 6 | Number of stored arguments |
| arg_ridx | input | 5 | Argument read index |
| arg_rdata | output | 8 | Argument at arg_ridx |
| rsp_wr | input | 1 | Reply buffer write strobe |
| rsp_widx | input | 5 | Reply buffer write index |
| rsp_wdata | input | 8 | Reply buffer write data |
| rsp_ready | input | 1 | Reply-ready pulse from the executor |
| rsp_cnt | input | 6 | Number of valid reply bytes (at most 32) |

## Verification
Properties watched on every cycle:
- sr_done always comes with a low acknowledge line.
- proto_err, hs_err and sr_done never overlap.
- disp_stb lasts a single cycle and only occurs while poll_hold is high.
- poll_hold rises only together with an accepted byte.

Only the bench's scenarios can show the rest:
- the contents and order of reply bytes, including zero padding and the leading count byte;
- argument saturation at 32;
- stalling a request until the reply is ready;
- the absence of a dispatch for unknown opcodes.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_WAIT = 2'd2,
      ST_RSP  = 2'd3
   } mbs_state_e;

   typedef struct packed {
      logic       known;
      logic       cmd_var;
      logic [7:0] cmd_len;
      logic       rsp_var;
      logic [7:0] rsp_len;
   } mbs_len_t;

   // Per-opcode length table, computed over all 256 codes.
   function automatic mbs_len_t mbs_lookup(input logic [7:0] op);
      mbs_len_t r;
      r       = '0;
      r.known = 1'b1;
      case (op)
         8'h10:   r.cmd_len = 8'd1;
         8'h20:   r.cmd_var = 1'b1;
         8'h30:   r.cmd_len = 8'd4;
         8'h38:   r.rsp_len = 8'd4;
         8'h78:   r.rsp_var = 1'b1;
         8'hE8:   r.rsp_len = 8'd1;
         default: begin
            r.known   = 1'b0;
            r.rsp_var = op[0];
            r.rsp_len = op[0] ? 8'd0 : {6'd0, op[2:1]};
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mbs_handshake.sv
module mbs_handshake #(
   parameter int W       = 8,
   parameter int ACK_BIT = 3,
   parameter int REQ_BIT = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         port_wr,
   input  logic [W-1:0] port_wdata,
   input  logic         stall,
   output logic [W-1:0] port_q,
   output logic         byte_evt,
   output logic         hs_err
);
   localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] IDLE_V = (ONE << ACK_BIT) | (ONE << REQ_BIT);

   generate
      if (ACK_BIT == REQ_BIT || ACK_BIT >= W || REQ_BIT >= W) begin : g_bad_bits
         $error("mbs_handshake: handshake bit positions invalid");
      end
   endgenerate

   logic [W-1:0] last_q, nxt;
   logic         changed, rel_evt, bad_evt;

   always_comb begin
      changed  = (port_q != last_q) && !stall;
      byte_evt = changed && !port_q[REQ_BIT] &&  port_q[ACK_BIT];
      rel_evt  = changed &&  port_q[REQ_BIT] && !port_q[ACK_BIT];
      bad_evt  = changed && !port_q[REQ_BIT] && !port_q[ACK_BIT];
      nxt      = port_q;
      if (byte_evt) nxt[ACK_BIT] = 1'b0;
      if (rel_evt)  nxt[ACK_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         port_q <= IDLE_V;
         last_q <= IDLE_V;
         hs_err <= 1'b0;
      end else begin
         hs_err <= bad_evt;
         if (changed) last_q <= nxt;
         port_q <= port_wr ? port_wdata : nxt;
      end
   end
endmodule

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
   parameter int DEPTH = 32,
   parameter int W     = 8,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [W-1:0]  wdata,
   input  logic [IW-1:0] ridx,
   output logic [W-1:0]  rdata
);
   generate
      if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
         $error("mbs_regfile: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdata;
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/mbox_byte_seq.sv
module mbox_byte_seq
   import mbs_pkg::*;
#(
   parameter int DEPTH   = 32,
   parameter int ACK_BIT = 3,
   parameter int REQ_BIT = 4,
   localparam int IW     = $clog2(DEPTH),
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          port_wr,
   input  logic [7:0]    port_wdata,
   output logic [7:0]    port_q,
   input  logic          sr_dir_out,
   input  logic [7:0]    sr_in,
   output logic [7:0]    sr_out,
   output logic          sr_done,
   output logic          proto_err,
   output logic          hs_err,
   output logic          poll_hold,
   output logic          disp_stb,
   output logic [7:0]    disp_op,
   output logic [CW-1:0] arg_cnt,
   input  logic [IW-1:0] arg_ridx,
   output logic [7:0]    arg_rdata,
   input  logic          rsp_wr,
   input  logic [IW-1:0] rsp_widx,
   input  logic [7:0]    rsp_wdata,
   input  logic          rsp_ready,
   input  logic [CW-1:0] rsp_cnt
);
   generate
      if (DEPTH < 4 || DEPTH > 128) begin : g_bad_depth
         $error("mbox_byte_seq: DEPTH out of range");
      end
   endgenerate

   mbs_state_e    state_q;
   logic [7:0]    op_q, cmd_len_q, rx_q;
   logic          len_pend_q, known_q, rsp_var_q, need_size_q;
   logic [CW-1:0] rsp_fix_q, rsp_len_q, rsp_avail_q, rsp_pos_q;

   logic          byte_evt, stall;
   mbs_len_t      lk;
   logic          cmd_fin, fin_known, from_wait, go_rsp;
   logic          ent_var, ent_empty;
   logic [CW-1:0] ent_fix, ent_len, ent_avail;
   logic [7:0]    rsp_rdata, rsp_byte;
   logic          rsp_last, arg_we;

   assign stall = (state_q == ST_WAIT);

   mbs_handshake #(.W(8), .ACK_BIT(ACK_BIT), .REQ_BIT(REQ_BIT)) u_hs (
      .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
      .stall(stall), .port_q(port_q), .byte_evt(byte_evt), .hs_err(hs_err)
   );

   assign arg_we = byte_evt && sr_dir_out && (state_q == ST_CMD) && !len_pend_q
                   && (rx_q < 8'(DEPTH));

   mbs_regfile #(.DEPTH(DEPTH), .W(8)) u_args (
      .clk(clk), .we(arg_we), .widx(rx_q[IW-1:0]), .wdata(sr_in),
      .ridx(arg_ridx), .rdata(arg_rdata)
   );

   mbs_regfile #(.DEPTH(DEPTH), .W(8)) u_rsp (
      .clk(clk), .we(rsp_wr), .widx(rsp_widx), .wdata(rsp_wdata),
      .ridx(rsp_pos_q[IW-1:0]), .rdata(rsp_rdata)
   );

   assign lk      = mbs_lookup(sr_in);
   assign disp_op = op_q;
   assign arg_cnt = (rx_q >= 8'(DEPTH)) ? CW'(DEPTH) : CW'(rx_q);

   always_comb begin
      fin_known = (state_q == ST_IDLE) ? lk.known : known_q;
      cmd_fin   = 1'b0;
      if (byte_evt && sr_dir_out) begin
         case (state_q)
            ST_IDLE: cmd_fin = !lk.cmd_var && (lk.cmd_len == 8'd0);
            ST_CMD:  cmd_fin = len_pend_q ? (sr_in == 8'd0)
                                          : ((rx_q + 8'd1) == cmd_len_q);
            default: cmd_fin = 1'b0;
         endcase
      end
      from_wait = (state_q == ST_WAIT);
      go_rsp    = (cmd_fin && !fin_known) || (from_wait && rsp_ready);
      ent_var   = (state_q == ST_IDLE) ? lk.rsp_var : rsp_var_q;
      ent_fix   = (state_q == ST_IDLE) ? CW'(lk.rsp_len) : rsp_fix_q;
      ent_len   = ent_var ? (from_wait ? rsp_cnt : '0) : ent_fix;
      ent_avail = from_wait ? rsp_cnt : '0;
      ent_empty = !ent_var && (ent_len == '0);
      rsp_byte  = (rsp_pos_q < rsp_avail_q) ? rsp_rdata : 8'h00;
      rsp_last  = ((rsp_pos_q + CW'(1)) == rsp_len_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         op_q        <= '0;
         cmd_len_q   <= '0;
         rx_q        <= '0;
         len_pend_q  <= 1'b0;
         known_q     <= 1'b0;
         rsp_var_q   <= 1'b0;
         rsp_fix_q   <= '0;
         rsp_len_q   <= '0;
         rsp_avail_q <= '0;
         rsp_pos_q   <= '0;
         need_size_q <= 1'b0;
         sr_out      <= '0;
         sr_done     <= 1'b0;
         proto_err   <= 1'b0;
         disp_stb    <= 1'b0;
         poll_hold   <= 1'b0;
      end else begin
         sr_done   <= 1'b0;
         proto_err <= 1'b0;
         disp_stb  <= 1'b0;
         if (byte_evt) begin
            case (state_q)
               ST_IDLE: begin
                  if (!sr_dir_out) begin
                     proto_err <= 1'b1;
                  end else begin
                     sr_done    <= 1'b1;
                     poll_hold  <= 1'b1;
                     op_q       <= sr_in;
                     known_q    <= lk.known;
                     rsp_var_q  <= lk.rsp_var;
                     rsp_fix_q  <= CW'(lk.rsp_len);
                     len_pend_q <= lk.cmd_var;
                     cmd_len_q  <= lk.cmd_len;
                     rx_q       <= '0;
                     state_q    <= ST_CMD;
                  end
               end
               ST_CMD: begin
                  if (!sr_dir_out) begin
                     proto_err <= 1'b1;
                  end else begin
                     sr_done <= 1'b1;
                     if (len_pend_q) begin
                        cmd_len_q  <= sr_in;
                        len_pend_q <= 1'b0;
                     end else begin
                        rx_q <= rx_q + 8'd1;
                     end
                  end
               end
               ST_RSP: begin
                  if (sr_dir_out) begin
                     proto_err <= 1'b1;
                  end else begin
                     sr_done <= 1'b1;
                     if (need_size_q) begin
                        sr_out      <= 8'(rsp_len_q);
                        need_size_q <= 1'b0;
                        if (rsp_len_q == '0) begin
                           state_q   <= ST_IDLE;
                           poll_hold <= 1'b0;
                        end
                     end else begin
                        sr_out    <= rsp_byte;
                        rsp_pos_q <= rsp_pos_q + CW'(1);
                        if (rsp_last) begin
                           state_q   <= ST_IDLE;
                           poll_hold <= 1'b0;
                        end
                     end
                  end
               end
               default: ;
            endcase
         end
         if (cmd_fin && fin_known) begin
            disp_stb <= 1'b1;
            state_q  <= ST_WAIT;
         end
         if (go_rsp) begin
            need_size_q <= ent_var;
            rsp_len_q   <= ent_len;
            rsp_avail_q <= ent_avail;
            rsp_pos_q   <= '0;
            if (ent_empty) begin
               state_q   <= ST_IDLE;
               poll_hold <= 1'b0;
            end else begin
               state_q   <= ST_RSP;
            end
         end
      end
   end
endmodule

// File: rtl/mbox_byte_seq_chk.sv
module mbox_byte_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic ack_n,
   input logic sr_done,
   input logic proto_err,
   input logic hs_err,
   input logic disp_stb,
   input logic poll_hold
);
   // R2: a handled byte always shows the acknowledge line driven low
   a_r2_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      sr_done |-> !ack_n);

   // R5: a direction mismatch never also counts as a shifted byte
   a_r5_err_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> !sr_done);

   // R4: an invalid handshake state handles no byte
   a_r4_bad_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
      hs_err |-> (!sr_done && !proto_err));

   // R9: dispatch is a single-cycle strobe
   a_r9_disp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      disp_stb |=> !disp_stb);

   // R13: dispatch only happens inside a held transaction
   a_r13_hold_disp: assert property (@(posedge clk) disable iff (!rst_n)
      disp_stb |-> poll_hold);

   // R13: the hold rises only with an accepted opcode byte
   a_r13_hold_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(poll_hold) |-> sr_done);
endmodule

bind mbox_byte_seq mbox_byte_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ack_n(port_q[ACK_BIT]), .sr_done(sr_done),
   .proto_err(proto_err), .hs_err(hs_err), .disp_stb(disp_stb),
   .poll_hold(poll_hold)
);

// File: tb/mbox_byte_seq_tb.sv
`timescale 1ns/1ps
module mbox_byte_seq_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_wr = 1'b0;
   logic [7:0] port_wdata = 8'h18;
   logic [7:0] port_q;
   logic       sr_dir_out = 1'b1;
   logic [7:0] sr_in = 8'h00;
   logic [7:0] sr_out;
   logic       sr_done, proto_err, hs_err, poll_hold, disp_stb;
   logic [7:0] disp_op;
   logic [5:0] arg_cnt;
   logic [4:0] arg_ridx = '0;
   logic [7:0] arg_rdata;
   logic       rsp_wr = 1'b0;
   logic [4:0] rsp_widx = '0;
   logic [7:0] rsp_wdata = '0;
   logic       rsp_ready = 1'b0;
   logic [5:0] rsp_cnt = '0;

   always #2 clk = ~clk;

   mbox_byte_seq u_dut (
      .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_wdata(port_wdata),
      .port_q(port_q), .sr_dir_out(sr_dir_out), .sr_in(sr_in), .sr_out(sr_out),
      .sr_done(sr_done), .proto_err(proto_err), .hs_err(hs_err),
      .poll_hold(poll_hold), .disp_stb(disp_stb), .disp_op(disp_op),
      .arg_cnt(arg_cnt), .arg_ridx(arg_ridx), .arg_rdata(arg_rdata),
      .rsp_wr(rsp_wr), .rsp_widx(rsp_widx), .rsp_wdata(rsp_wdata),
      .rsp_ready(rsp_ready), .rsp_cnt(rsp_cnt)
   );

   int n_chk = 0;
   int n_err = 0;
   int n_done = 0;
   logic [7:0] exp_q [$];
   logic [7:0] disp_q [$];
   logic [7:0] e_byte, e_op;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: reply bytes and dispatch strobes
   always @(negedge clk) begin
      if (rst_n) begin
         if (sr_done) n_done++;
         if (sr_done && !sr_dir_out) begin
            if (exp_q.size() == 0) chk(1'b0, "R10 unexpected reply byte", sr_out, 0);
            else begin
               e_byte = exp_q.pop_front();
               chk(sr_out == e_byte, "R10/R11/R12 reply byte", sr_out, e_byte);
            end
         end
         if (disp_stb) begin
            if (disp_q.size() == 0) chk(1'b0, "R12 unexpected dispatch", disp_op, 0);
            else begin
               e_op = disp_q.pop_front();
               chk(disp_op == e_op, "R9 dispatch opcode", disp_op, e_op);
            end
         end
      end
   end

   task automatic req_begin(input logic dir, input logic [7:0] d);
      sr_dir_out = dir;
      sr_in      = d;
      port_wr    = 1'b1;
      port_wdata = 8'h08;
      @(negedge clk);
      port_wr    = 1'b0;
   endtask

   task automatic req_finish(output logic done, output logic err);
      done = 1'b0;
      err  = 1'b0;
      for (int i = 0; i < 100; i++) begin
         if (!port_q[3]) break;
         @(negedge clk);
      end
      done = sr_done;
      err  = proto_err;
      port_wr    = 1'b1;
      port_wdata = 8'h10;
      @(negedge clk);
      port_wr    = 1'b0;
      for (int i = 0; i < 100; i++) begin
         if (port_q == 8'h18) break;
         @(negedge clk);
      end
   endtask

   task automatic send(input logic dir, input logic [7:0] d, input string tag);
      logic dn, er;
      req_begin(dir, d);
      req_finish(dn, er);
      chk(dn && !er, tag, {dn, er}, 2);
   endtask

   task automatic supply(input int cnt, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2);
      logic [7:0] bs [3];
      bs[0] = b0; bs[1] = b1; bs[2] = b2;
      for (int i = 0; i < 3; i++) begin
         rsp_wr = 1'b1; rsp_widx = 5'(i); rsp_wdata = bs[i];
         @(negedge clk);
      end
      rsp_wr    = 1'b0;
      rsp_cnt   = 6'(cnt);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   task automatic read_arg(input int idx, output logic [7:0] v);
      arg_ridx = 5'(idx);
      #1 v = arg_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic dn, er;
      logic [7:0] v;
      int d0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(port_q == 8'h18, "R1 port reset value", port_q, 8'h18);
      chk(!poll_hold && !sr_done && !disp_stb && !proto_err && !hs_err,
          "R1 outputs idle", {poll_hold, sr_done, disp_stb}, 0);

      // R6/R13: fixed one-argument command, no reply bytes
      send(1'b1, 8'h10, "R2 opcode byte");
      chk(poll_hold, "R13 hold after opcode", poll_hold, 1);
      disp_q.push_back(8'h10);
      send(1'b1, 8'h5A, "R2 argument byte");
      repeat (2) @(negedge clk);
      chk(arg_cnt == 6'd1, "R6 argument count", arg_cnt, 1);
      read_arg(0, v);
      chk(v == 8'h5A, "R6 argument value", v, 8'h5A);
      supply(0, 8'h0, 8'h0, 8'h0);
      @(negedge clk);
      chk(!poll_hold, "R13 hold released, empty reply", poll_hold, 0);
      chk(port_q == 8'h18, "R3 port idle after release", port_q, 8'h18);

      // R9/R10: request held while waiting, zero padding past rsp_cnt
      disp_q.push_back(8'h38);
      send(1'b1, 8'h38, "R2 opcode 0x38");
      req_begin(1'b0, 8'h00);
      repeat (8) @(negedge clk);
      chk(port_q == 8'h08, "R9 request stalled until ready", port_q, 8'h08);
      exp_q.push_back(8'h11); exp_q.push_back(8'h22);
      exp_q.push_back(8'h33); exp_q.push_back(8'h00);
      supply(3, 8'h11, 8'h22, 8'h33);
      req_finish(dn, er);
      chk(dn && !er, "R9 stalled request served", {dn, er}, 2);
      for (int i = 0; i < 3; i++) send(1'b0, 8'h00, "R10 reply read");
      chk(exp_q.size() == 0 && !poll_hold, "R10 reply complete", exp_q.size(), 0);

      // R7/R8: variable length 34, only 32 stored
      send(1'b1, 8'h20, "R7 opcode 0x20");
      send(1'b1, 8'd34, "R7 length byte");
      for (int k = 0; k < 34; k++) begin
         if (k == 33) disp_q.push_back(8'h20);
         send(1'b1, 8'(k + 1), "R8 argument");
      end
      repeat (2) @(negedge clk);
      chk(arg_cnt == 6'd32, "R8 arg count saturates", arg_cnt, 32);
      read_arg(0, v);
      chk(v == 8'd1, "R8 first argument", v, 1);
      read_arg(31, v);
      chk(v == 8'd32, "R8 last stored argument", v, 32);
      chk(disp_q.size() == 0, "R8 dispatch after full count", disp_q.size(), 0);
      supply(0, 8'h0, 8'h0, 8'h0);
      @(negedge clk);
      chk(!poll_hold, "R13 hold released", poll_hold, 0);

      // R7: count of zero dispatches at once
      send(1'b1, 8'h20, "R7 opcode 0x20");
      disp_q.push_back(8'h20);
      send(1'b1, 8'd0, "R7 zero length");
      repeat (2) @(negedge clk);
      chk(disp_q.size() == 0 && arg_cnt == 6'd0, "R7 immediate dispatch",
          disp_q.size(), 0);
      supply(0, 8'h0, 8'h0, 8'h0);

      // R5: direction error in idle
      d0 = n_done;
      req_begin(1'b0, 8'h38);
      req_finish(dn, er);
      chk(er && !dn, "R5 idle direction error", {dn, er}, 1);
      chk(!poll_hold && n_done == d0, "R5 byte not consumed", n_done - d0, 0);

      // R11 and R5 in reply phase
      disp_q.push_back(8'h78);
      send(1'b1, 8'h78, "R2 opcode 0x78");
      exp_q.push_back(8'd2); exp_q.push_back(8'hAA); exp_q.push_back(8'hBB);
      supply(2, 8'hAA, 8'hBB, 8'h00);
      req_begin(1'b1, 8'h00);
      req_finish(dn, er);
      chk(er && !dn, "R5 reply direction error", {dn, er}, 1);
      for (int i = 0; i < 3; i++) send(1'b0, 8'h00, "R11 reply read");
      chk(exp_q.size() == 0 && !poll_hold, "R11 variable reply done", exp_q.size(), 0);

      // R12: unknown opcodes
      exp_q.push_back(8'h00); exp_q.push_back(8'h00); exp_q.push_back(8'h00);
      send(1'b1, 8'h06, "R12 unknown fixed opcode");
      for (int i = 0; i < 3; i++) send(1'b0, 8'h00, "R12 zero reply read");
      chk(exp_q.size() == 0 && !poll_hold, "R12 fixed zeros", exp_q.size(), 0);
      exp_q.push_back(8'h00);
      send(1'b1, 8'h41, "R12 unknown variable opcode");
      send(1'b0, 8'h00, "R12 empty count read");
      chk(exp_q.size() == 0 && !poll_hold, "R12 empty variable reply", exp_q.size(), 0);
      send(1'b1, 8'h08, "R12 unknown empty opcode");
      chk(!poll_hold, "R12 no reply returns to idle", poll_hold, 0);

      // fixed one-byte reply
      disp_q.push_back(8'hE8);
      send(1'b1, 8'hE8, "R2 opcode 0xE8");
      exp_q.push_back(8'h07);
      supply(1, 8'h07, 8'h00, 8'h00);
      send(1'b0, 8'h00, "R10 single reply");
      chk(exp_q.size() == 0 && !poll_hold, "R10 one-byte reply", exp_q.size(), 0);

      // R4: invalid state and unchanged writes
      d0 = n_done;
      port_wr = 1'b1; port_wdata = 8'h00;
      @(negedge clk);
      port_wr = 1'b0;
      v = 8'h00;
      for (int i = 0; i < 5; i++) begin
         if (hs_err) v = 8'h01;
         @(negedge clk);
      end
      chk(v == 8'h01, "R4 invalid state flagged", v, 1);
      chk(port_q == 8'h00 && n_done == d0, "R4 no byte, port untouched", port_q, 0);
      port_wr = 1'b1; port_wdata = 8'h18;
      @(negedge clk);
      port_wr = 1'b1; port_wdata = 8'h18;
      @(negedge clk);
      port_wr = 1'b0;
      repeat (4) @(negedge clk);
      chk(port_q == 8'h18 && n_done == d0 && !poll_hold, "R4 unchanged value inert",
          port_q, 8'h18);

      chk(disp_q.size() == 0 && exp_q.size() == 0, "R9 scoreboard drained",
          disp_q.size() + exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule